// File: doc/BRIEF.md
# Serial port register block with split interrupt lines

This block is the host-facing register file of a classic byte-oriented serial port. A processor reaches it over a simple word-indexed bus with single-cycle read and write strobes. The block holds the line, modem and FIFO configuration, collects receive and transmit status, and produces the baud tick. It hands characters to and from a serialising core through plain valid/ready style strobes. The bit-level shifters and the FIFO storage live in that core and are not part of this block.

There is no interrupt identification register. The block drives four separate interrupt request lines instead: transmit ready, receive data, line error and modem change. An auxiliary status register reports whether a pending receive interrupt came from a character timeout. The divisor is one register the full width of the bus, with no banked access. Loopback routes the transmit line and the modem control outputs back inside the block, and a break control forces the serial output low.

Top module: `serial_port_regs`

## Requirements
- R1: Register indexes are 0 receive buffer (read only), 1 transmit holding (write only, reads 0), 2 FIFO control, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 divisor, 8 auxiliary status. Line control reads back all 8 bits, and its low 6 bits drive `line_cfg`. Modem control reads back bits [4:0], with bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2 and bit 4 loopback. The divisor reads back in full. A write to index 0 has no effect.
- R2: A write to index 1 while the holding register is empty loads the byte and raises `tx_valid`. `tx_data` then holds that byte until a cycle with `tx_ready`, after which `tx_valid` drops. A write while the register is full is ignored. Line status bit 5 is 1 when the holding register is empty, and bit 6 is 1 when it is empty and `tx_idle` is high.
- R3: A cycle with `rx_valid` and no unread byte stores `rx_data` and sets line status bit 0. A read of index 0 returns the stored byte and clears bit 0.
- R4: `rx_valid` while a byte is unread sets overrun (line status bit 1) and discards the new byte.
- R5: `rx_perr`, `rx_ferr` and `rx_brk` on an accepted byte set line status bits 2, 3 and 4. Bit 7 is 1 while any of these three is set. A read of index 5 clears bits 1 to 4.
- R6: Modem status bits 4 to 7 show the current CTS, DSR, RI and DCD levels. Bits 0, 1 and 3 latch any change of CTS, DSR and DCD. Bit 2 latches a 1-to-0 transition of RI. A read of index 6 clears bits 0 to 3.
- R7: With loopback set, the modem status levels come from modem control (CTS from RTS, DSR from DTR, RI from OUT1, DCD from OUT2), the external pins are ignored, the four modem outputs are low, `sout` idles high and `sin_core` follows `tx_line`. Without loopback, `sin_core` follows `sin` and `sout` follows `tx_line`.
- R8: While line control bit 6 is set, `sout` is low from the next cycle on.
- R9: With a divisor N ≥ 1, `baud_tick` pulses once every N cycles. With N = 0 there are no ticks. Writing the divisor restarts the count.
- R10: `irq_tx` is line status bit 5, `irq_rx` is line status bit 0 OR the timeout flag, `irq_ls` is the OR of line status bits 1 to 4, and `irq_msr` is the OR of modem status bits 0 to 3. Each output is registered and follows its state one cycle later.
- R11: A `rx_timeout` pulse sets auxiliary status bit 0 and raises the receive interrupt. A read of index 0 clears the bit. Bit 0 reads 0 when the interrupt comes only from received data.
- R12: FIFO control keeps bit 0 (enable, driving `fifo_en`) and bits 7:6 (trigger level, driving `rx_trig`). Bit 1 and bit 2 read back 0. Writing 1 to bit 1 gives a one-cycle `rx_flush` pulse and discards the unread byte and the timeout flag. Writing 1 to bit 2 gives a one-cycle `tx_flush` pulse and empties the holding register.
- R13: After reset, line status reads 0x60 with `tx_idle` high, modem status reads 0, the divisor reads its reset value (16), `sout` is high, and `irq_tx` is the only interrupt raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered, valid the cycle after the strobe |
| tx_valid | output | 1 | Holding register has a byte for the core |
| tx_data | output | 8 | Byte offered to the core |
| tx_ready | input | 1 | Core takes the offered byte |
| tx_idle | input | 1 | Core shifter is empty |
| rx_valid | input | 1 | Core delivers a received byte |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error on the delivered byte |
| rx_ferr | input | 1 | Framing error on the delivered byte |
| rx_brk | input | 1 | Break seen on the delivered byte |
| rx_timeout | input | 1 | Character timeout pulse from the core |
| tx_line | input | 1 | Serial output of the core's transmitter |
| sout | output | 1 | Serial output pin, registered |
| sin | input | 1 | Serial input pin |
| sin_core | output | 1 | Serial input toward the core's receiver |
| m_cts | input | 1 | Clear-to-send level |
| m_dsr | input | 1 | Data-set-ready level |
| m_ri | input | 1 | Ring indicator level |
| m_dcd | input | 1 | Carrier detect level |
| m_dtr | output | 1 | Data-terminal-ready output |
| m_rts | output | 1 | Request-to-send output |
| m_out1 | output | 1 | User output 1 |
| m_out2 | output | 1 | User output 2 |
| line_cfg | output | 6 | Word length, stop, parity controls for the core |
| fifo_en | output | 1 | FIFO enable for the core |
| rx_trig | output | 2 | Receive trigger level code for the core |
| rx_flush | output | 1 | One-cycle receive FIFO clear |
| tx_flush | output | 1 | One-cycle transmit FIFO clear |
| baud_tick | output | 1 | One pulse per divisor period |
| irq_tx | output | 1 | Transmit ready interrupt |
| irq_rx | output | 1 | Receive data interrupt |
| irq_ls | output | 1 | Line error interrupt |
| irq_msr | output | 1 | Modem change interrupt |

## Verification
The bench targets the read-to-clear corners. If the line status read left overrun or error bits set, `irq_ls` would stay high. If the modem read failed to clear the deltas, `irq_msr` would hang. A design that latched RI on the rising edge would report a delta when the ring starts instead of when it ends.

A byte arriving while one is unread must keep the first byte and flag overrun; a design that overwrote would return the second byte. A second transmit write while full must leave `tx_data` unchanged. Loopback must ignore the external modem pins, drop the modem outputs and idle `sout` high. A design that kept the pins live would show the wrong levels.

The divisor boundaries are checked exactly: ten ticks in fifty cycles for 5, and none for 0, where an off-by-one counter gives a different count. The timeout flag must tell a timeout apart from data, so auxiliary status has to read 1 after a timeout and 0 after the receive buffer read.

// File: rtl/sp_pkg.sv
package sp_pkg;

  // Register word indexes; the host software decodes by these numbers.
  localparam int IDX_RXBUF     = 0;
  localparam int IDX_TXHOLD    = 1;
  localparam int IDX_FIFOCTL   = 2;
  localparam int IDX_LINECTL   = 3;
  localparam int IDX_MODEMCTL  = 4;
  localparam int IDX_LINESTAT  = 5;
  localparam int IDX_MODEMSTAT = 6;
  localparam int IDX_DIVISOR   = 7;
  localparam int IDX_AUXSTAT   = 8;

  localparam int LCR_BREAK_BIT = 6;
  localparam int MCR_LOOP_BIT  = 4;

  // Modem line levels, packed so that they map onto modem status [7:4].
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lines_t;

endpackage

// File: rtl/sp_baud_gen.sv
module sp_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (divisor == '0) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= divisor - 1'b1) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end

endmodule

// File: rtl/sp_modem_status.sv
module sp_modem_status
  import sp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       loop_en,
  input  logic [3:0] mctl,      // {out2, out1, rts, dtr}
  input  mdm_lines_t pins,
  input  logic       rd_clear,
  output logic [7:0] msr
);

  mdm_lines_t lvl_q, lvl_nxt;
  logic [3:0] delta_q;         // {ddcd, teri, ddsr, dcts}
  logic [3:0] delta_new;

  always_comb begin
    if (loop_en) begin
      lvl_nxt.cts = mctl[1];
      lvl_nxt.dsr = mctl[0];
      lvl_nxt.ri  = mctl[2];
      lvl_nxt.dcd = mctl[3];
    end else begin
      lvl_nxt = pins;
    end
    delta_new[0] = lvl_q.cts ^ lvl_nxt.cts;
    delta_new[1] = lvl_q.dsr ^ lvl_nxt.dsr;
    delta_new[2] = lvl_q.ri & ~lvl_nxt.ri;
    delta_new[3] = lvl_q.dcd ^ lvl_nxt.dcd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      delta_q <= '0;
    end else begin
      lvl_q   <= lvl_nxt;
      delta_q <= (rd_clear ? 4'b0000 : delta_q) | delta_new;
    end
  end

  assign msr = {lvl_q, delta_q};

endmodule

// File: rtl/sp_rx_status.sv
module sp_rx_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       rx_brk,
  input  logic       rx_timeout,
  input  logic       rd_buf,
  input  logic       rd_stat,
  input  logic       flush,
  output logic [7:0] buf_q,
  output logic       ready_q,
  output logic       ovr_q,
  output logic       par_q,
  output logic       frm_q,
  output logic       brk_q,
  output logic       tmo_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q   <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
      par_q   <= 1'b0;
      frm_q   <= 1'b0;
      brk_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      if (rd_buf || flush) begin
        ready_q <= 1'b0;
        tmo_q   <= 1'b0;
      end
      if (rd_stat) begin
        ovr_q <= 1'b0;
        par_q <= 1'b0;
        frm_q <= 1'b0;
        brk_q <= 1'b0;
      end
      if (rx_timeout) tmo_q <= 1'b1;
      if (rx_valid) begin
        if (ready_q && !rd_buf && !flush) begin
          ovr_q <= 1'b1;
        end else begin
          buf_q   <= rx_data;
          ready_q <= 1'b1;
          if (rx_perr) par_q <= 1'b1;
          if (rx_ferr) frm_q <= 1'b1;
          if (rx_brk)  brk_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import sp_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int DIV_RESET = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              tx_idle,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  input  logic              rx_timeout,
  input  logic              tx_line,
  output logic              sout,
  input  logic              sin,
  output logic              sin_core,
  input  logic              m_cts,
  input  logic              m_dsr,
  input  logic              m_ri,
  input  logic              m_dcd,
  output logic              m_dtr,
  output logic              m_rts,
  output logic              m_out1,
  output logic              m_out2,
  output logic [5:0]        line_cfg,
  output logic              fifo_en,
  output logic [1:0]        rx_trig,
  output logic              rx_flush,
  output logic              tx_flush,
  output logic              baud_tick,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_ls,
  output logic              irq_msr
);

  localparam int DIV_W = DATA_W;

  // Register state
  logic [7:0]       lcr_q;
  logic [4:0]       mcr_q;
  logic             fen_q;
  logic [1:0]       trig_q;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       thr_q;
  logic             thr_full;

  // Receive side status
  logic [7:0] rbuf;
  logic       dr, oe, pe, fe, bi, tmo;
  logic [7:0] lsr, msr;
  mdm_lines_t pin_lvl;

  // Bus decode
  logic wr_thr, wr_fcr, wr_lcr, wr_mcr, wr_div;
  logic rd_rbr, rd_lsr, rd_msr;
  logic rxclr_cmd, txclr_cmd, loop_en;

  always_comb begin
    wr_thr    = bus_wr && (bus_addr == ADDR_W'(IDX_TXHOLD));
    wr_fcr    = bus_wr && (bus_addr == ADDR_W'(IDX_FIFOCTL));
    wr_lcr    = bus_wr && (bus_addr == ADDR_W'(IDX_LINECTL));
    wr_mcr    = bus_wr && (bus_addr == ADDR_W'(IDX_MODEMCTL));
    wr_div    = bus_wr && (bus_addr == ADDR_W'(IDX_DIVISOR));
    rd_rbr    = bus_rd && (bus_addr == ADDR_W'(IDX_RXBUF));
    rd_lsr    = bus_rd && (bus_addr == ADDR_W'(IDX_LINESTAT));
    rd_msr    = bus_rd && (bus_addr == ADDR_W'(IDX_MODEMSTAT));
    rxclr_cmd = wr_fcr && bus_wdata[1];
    txclr_cmd = wr_fcr && bus_wdata[2];
    loop_en   = mcr_q[MCR_LOOP_BIT];
  end

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q    <= '0;
      mcr_q    <= '0;
      fen_q    <= 1'b0;
      trig_q   <= '0;
      div_q    <= DIV_W'(DIV_RESET);
      rx_flush <= 1'b0;
      tx_flush <= 1'b0;
    end else begin
      if (wr_lcr) lcr_q <= bus_wdata[7:0];
      if (wr_mcr) mcr_q <= bus_wdata[4:0];
      if (wr_div) div_q <= bus_wdata;
      if (wr_fcr) begin
        fen_q  <= bus_wdata[0];
        trig_q <= bus_wdata[7:6];
      end
      rx_flush <= rxclr_cmd;
      tx_flush <= txclr_cmd;
    end
  end

  // Transmit holding register and core handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q    <= '0;
      thr_full <= 1'b0;
    end else if (txclr_cmd) begin
      thr_full <= 1'b0;
    end else if (thr_full) begin
      if (tx_ready) thr_full <= 1'b0;
    end else if (wr_thr) begin
      thr_q    <= bus_wdata[7:0];
      thr_full <= 1'b1;
    end
  end

  assign tx_valid = thr_full;
  assign tx_data  = thr_q;

  sp_rx_status u_rx (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_perr    (rx_perr),
    .rx_ferr    (rx_ferr),
    .rx_brk     (rx_brk),
    .rx_timeout (rx_timeout),
    .rd_buf     (rd_rbr),
    .rd_stat    (rd_lsr),
    .flush      (rxclr_cmd),
    .buf_q      (rbuf),
    .ready_q    (dr),
    .ovr_q      (oe),
    .par_q      (pe),
    .frm_q      (fe),
    .brk_q      (bi),
    .tmo_q      (tmo)
  );

  always_comb begin
    pin_lvl.cts = m_cts;
    pin_lvl.dsr = m_dsr;
    pin_lvl.ri  = m_ri;
    pin_lvl.dcd = m_dcd;
  end

  sp_modem_status u_msr (
    .clk      (clk),
    .rst      (rst),
    .loop_en  (loop_en),
    .mctl     (mcr_q[3:0]),
    .pins     (pin_lvl),
    .rd_clear (rd_msr),
    .msr      (msr)
  );

  sp_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .restart (wr_div),
    .divisor (div_q),
    .tick    (baud_tick)
  );

  assign lsr = {pe | fe | bi, ~thr_full & tx_idle, ~thr_full, bi, fe, pe, oe, dr};

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (int'(bus_addr))
        IDX_RXBUF:     bus_rdata <= DATA_W'(rbuf);
        IDX_FIFOCTL:   bus_rdata <= DATA_W'({trig_q, 5'b00000, fen_q});
        IDX_LINECTL:   bus_rdata <= DATA_W'(lcr_q);
        IDX_MODEMCTL:  bus_rdata <= DATA_W'(mcr_q);
        IDX_LINESTAT:  bus_rdata <= DATA_W'(lsr);
        IDX_MODEMSTAT: bus_rdata <= DATA_W'(msr);
        IDX_DIVISOR:   bus_rdata <= div_q;
        IDX_AUXSTAT:   bus_rdata <= DATA_W'(tmo);
        default:       bus_rdata <= '0;
      endcase
    end else begin
      bus_rdata <= '0;
    end
  end

  // Interrupt lines and serial pin, all registered
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_tx  <= 1'b0;
      irq_rx  <= 1'b0;
      irq_ls  <= 1'b0;
      irq_msr <= 1'b0;
      sout    <= 1'b1;
    end else begin
      irq_tx  <= ~thr_full;
      irq_rx  <= dr | tmo;
      irq_ls  <= oe | pe | fe | bi;
      irq_msr <= |msr[3:0];
      sout    <= lcr_q[LCR_BREAK_BIT] ? 1'b0 : (loop_en ? 1'b1 : tx_line);
    end
  end

  assign sin_core = loop_en ? tx_line : sin;
  assign m_dtr    = mcr_q[0] & ~loop_en;
  assign m_rts    = mcr_q[1] & ~loop_en;
  assign m_out1   = mcr_q[2] & ~loop_en;
  assign m_out2   = mcr_q[3] & ~loop_en;
  assign line_cfg = lcr_q[5:0];
  assign fifo_en  = fen_q;
  assign rx_trig  = trig_q;

endmodule

// File: rtl/sp_regs_chk.sv
module sp_regs_chk #(
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rx_valid,
  input logic              rx_timeout,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              irq_rx,
  input logic              irq_ls,
  input logic              sout,
  input logic              baud_tick,
  input logic              brk_ctl,
  input logic [DIV_W-1:0]  div_val
);

  logic fcr_wr, div_wr, rbr_rd, lsr_rd;
  assign fcr_wr = bus_wr && (bus_addr == ADDR_W'(2));
  assign div_wr = bus_wr && (bus_addr == ADDR_W'(7));
  assign rbr_rd = bus_rd && (bus_addr == ADDR_W'(0));
  assign lsr_rd = bus_rd && (bus_addr == ADDR_W'(5));

  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !fcr_wr) |=> (tx_valid && $stable(tx_data)));

  // R2
  tx_done_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_valid);

  // R8
  brk_low_chk: assert property (@(posedge clk) disable iff (rst)
    brk_ctl |=> !sout);

  // R5
  ls_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !rx_valid) |=> ##1 !irq_ls);

  // R3
  rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rbr_rd && !rx_valid && !rx_timeout) |=> ##1 !irq_rx);

  // R9
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (baud_tick && div_val > DIV_W'(1) && !div_wr) |=> !baud_tick);

endmodule

bind serial_port_regs sp_regs_chk #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .rx_valid   (rx_valid),
  .rx_timeout (rx_timeout),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .irq_rx     (irq_rx),
  .irq_ls     (irq_ls),
  .sout       (sout),
  .baud_tick  (baud_tick),
  .brk_ctl    (lcr_q[6]),
  .div_val    (div_q)
);

// File: tb/serial_port_regs_test.sv
module serial_port_regs_test;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              tx_valid;
  logic [7:0]        tx_data;
  logic              tx_ready = 1'b0;
  logic              tx_idle = 1'b1;
  logic              rx_valid = 1'b0;
  logic [7:0]        rx_data = '0;
  logic              rx_perr = 1'b0;
  logic              rx_ferr = 1'b0;
  logic              rx_brk = 1'b0;
  logic              rx_timeout = 1'b0;
  logic              tx_line = 1'b1;
  logic              sout;
  logic              sin = 1'b1;
  logic              sin_core;
  logic              m_cts = 1'b0;
  logic              m_dsr = 1'b0;
  logic              m_ri = 1'b0;
  logic              m_dcd = 1'b0;
  logic              m_dtr, m_rts, m_out1, m_out2;
  logic [5:0]        line_cfg;
  logic              fifo_en;
  logic [1:0]        rx_trig;
  logic              rx_flush, tx_flush, baud_tick;
  logic              irq_tx, irq_rx, irq_ls, irq_msr;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  serial_port_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int idx, input logic [DATA_W-1:0] val);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(idx); bus_wdata = val;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [DATA_W-1:0] val);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ADDR_W'(idx);
    @(negedge clk);
    bus_rd = 1'b0;
    val = bus_rdata;
  endtask

  task automatic rx_byte(input logic [7:0] d, input logic p, input logic f, input logic b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
    @(negedge clk);
    rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic t_reset;
    logic [DATA_W-1:0] v;
    cycles(2);
    check("R13 irq_tx", irq_tx, 1);
    check("R13 other irqs", {irq_rx, irq_ls, irq_msr}, 0);
    check("R13 sout", sout, 1);
    check("R13 tx_valid", tx_valid, 0);
    rd(5, v); check("R13 line status", v, 16'h60);
    rd(6, v); check("R13 modem status", v, 0);
    rd(7, v); check("R13 divisor", v, 16);
  endtask

  task automatic t_regs;
    logic [DATA_W-1:0] v;
    wr(3, 16'h1B); rd(3, v); check("R1 line ctl", v, 16'h1B);
    check("R1 line_cfg", line_cfg, 6'h1B);
    wr(4, 16'h0F); rd(4, v); check("R1 modem ctl", v, 16'h0F);
    check("R1 modem pins", {m_out2, m_out1, m_rts, m_dtr}, 4'hF);
    wr(4, 16'h00);
    wr(7, 16'h1234); rd(7, v); check("R1 divisor", v, 16'h1234);
    rd(1, v); check("R1 txhold reads 0", v, 0);
    wr(0, 16'h00AA); rd(5, v); check("R1 rxbuf write ignored", v, 16'h60);
    wr(3, 16'h03);
  endtask

  task automatic t_tx;
    logic [DATA_W-1:0] v;
    tx_ready = 1'b0;
    wr(1, 16'hA5);
    check("R2 tx_valid", tx_valid, 1);
    check("R2 tx_data", tx_data, 8'hA5);
    cycles(1);
    check("R10 irq_tx low", irq_tx, 0);
    rd(5, v); check("R2 lsr full", v, 16'h00);
    wr(1, 16'h5A);
    check("R2 write while full ignored", tx_data, 8'hA5);
    tx_idle = 1'b0;
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    check("R2 tx_valid drop", tx_valid, 0);
    rd(5, v); check("R2 lsr shifter busy", v, 16'h20);
    tx_idle = 1'b1;
    rd(5, v); check("R2 lsr empty", v, 16'h60);
    check("R10 irq_tx back", irq_tx, 1);
  endtask

  task automatic t_rx;
    logic [DATA_W-1:0] v;
    rx_byte(8'h3C, 0, 0, 0);
    cycles(1);
    check("R10 irq_rx", irq_rx, 1);
    rd(5, v); check("R3 data ready", v, 16'h61);
    rd(0, v); check("R3 byte", v, 16'h3C);
    cycles(1);
    check("R3 irq_rx cleared", irq_rx, 0);
    rd(5, v); check("R3 ready cleared", v, 16'h60);
  endtask

  task automatic t_overrun;
    logic [DATA_W-1:0] v;
    rx_byte(8'h11, 0, 0, 0);
    rx_byte(8'h22, 0, 0, 0);
    cycles(1);
    check("R10 irq_ls", irq_ls, 1);
    rd(5, v); check("R4 overrun", v, 16'h63);
    cycles(1);
    check("R5 irq_ls cleared", irq_ls, 0);
    rd(0, v); check("R4 first byte kept", v, 16'h11);
  endtask

  task automatic t_errors;
    logic [DATA_W-1:0] v;
    rx_byte(8'h55, 1, 0, 0);
    rd(5, v); check("R5 parity", v, 16'hE5);
    rd(5, v); check("R5 read clears", v, 16'h61);
    rd(0, v); check("R5 byte", v, 16'h55);
    rx_byte(8'h00, 0, 1, 1);
    rd(5, v); check("R5 frame+break", v, 16'hF9);
    rd(0, v);
    rd(5, v); check("R5 cleared", v, 16'h60);
  endtask

  task automatic t_timeout;
    logic [DATA_W-1:0] v;
    @(negedge clk); rx_timeout = 1'b1;
    @(negedge clk); rx_timeout = 1'b0;
    cycles(1);
    check("R11 irq_rx on timeout", irq_rx, 1);
    rd(8, v); check("R11 aux timeout", v, 1);
    rd(0, v);
    cycles(1);
    rd(8, v); check("R11 aux cleared", v, 0);
    check("R11 irq_rx cleared", irq_rx, 0);
    rx_byte(8'h42, 0, 0, 0);
    rd(8, v); check("R11 data not timeout", v, 0);
    rd(0, v);
  endtask

  task automatic t_modem;
    logic [DATA_W-1:0] v;
    @(negedge clk); m_cts = 1'b1;
    cycles(2);
    check("R10 irq_msr", irq_msr, 1);
    rd(6, v); check("R6 cts delta", v, 16'h11);
    rd(6, v); check("R6 read clears", v, 16'h10);
    cycles(1);
    check("R6 irq_msr cleared", irq_msr, 0);
    @(negedge clk); m_ri = 1'b1;
    cycles(2);
    rd(6, v); check("R6 ri rise no delta", v, 16'h50);
    @(negedge clk); m_ri = 1'b0;
    cycles(2);
    rd(6, v); check("R6 ri trailing edge", v, 16'h14);
    @(negedge clk); m_dcd = 1'b1;
    cycles(2);
    rd(6, v); check("R6 dcd delta", v, 16'h98);
    @(negedge clk); m_cts = 1'b0; m_dcd = 1'b0;
    cycles(2);
    rd(6, v);
    rd(6, v); check("R6 idle", v, 0);
  endtask

  task automatic t_loop;
    logic [DATA_W-1:0] v;
    tx_line = 1'b0;
    wr(4, 16'h13);
    cycles(2);
    check("R7 modem outputs off", {m_out2, m_out1, m_rts, m_dtr}, 0);
    check("R7 sout idle", sout, 1);
    rd(6, v); check("R7 looped levels", v, 16'h33);
    sin = 1'b1;
    cycles(1);
    check("R7 sin_core from tx_line", sin_core, 0);
    tx_line = 1'b1;
    cycles(1);
    check("R7 sin_core follows", sin_core, 1);
    @(negedge clk); m_cts = 1'b1; m_dcd = 1'b1;
    cycles(2);
    rd(6, v); check("R7 pins ignored", v, 16'h30);
    m_cts = 1'b0; m_dcd = 1'b0;
    wr(4, 16'h00);
    cycles(2);
    rd(6, v);
    rd(6, v); check("R7 back to pins", v, 0);
    sin = 1'b0;
    cycles(1);
    check("R7 sin_core from sin", sin_core, 0);
    sin = 1'b1;
  endtask

  task automatic t_break;
    tx_line = 1'b1;
    wr(3, 16'h43);
    cycles(1);
    check("R8 break low", sout, 0);
    cycles(3);
    check("R8 break held", sout, 0);
    wr(3, 16'h03);
    cycles(1);
    check("R8 break released", sout, 1);
  endtask

  task automatic t_fifo;
    logic [DATA_W-1:0] v;
    wr(2, 16'hC1);
    check("R12 fifo_en", fifo_en, 1);
    check("R12 rx_trig", rx_trig, 2'b11);
    rd(2, v); check("R12 fcr readback", v, 16'hC1);
    rx_byte(8'h77, 0, 0, 0);
    wr(2, 16'hC3);
    check("R12 rx_flush pulse", rx_flush, 1);
    cycles(1);
    check("R12 rx_flush one cycle", rx_flush, 0);
    rd(5, v); check("R12 rx discarded", v, 16'h60);
    rd(2, v); check("R12 clear bits read 0", v, 16'hC1);
    tx_ready = 1'b0;
    wr(1, 16'h99);
    wr(2, 16'hC5);
    check("R12 tx_flush pulse", tx_flush, 1);
    check("R12 holding emptied", tx_valid, 0);
  endtask

  task automatic t_baud;
    int n;
    wr(7, 16'd5);
    n = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (baud_tick) n++;
    end
    check("R9 ticks div5", n, 10);
    wr(7, 16'd1);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (baud_tick) n++;
    end
    check("R9 ticks div1", n, 10);
    wr(7, 16'd0);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (baud_tick) n++;
    end
    check("R9 no ticks div0", n, 0);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_tx();
    t_rx();
    t_overrun();
    t_errors();
    t_timeout();
    t_modem();
    t_loop();
    t_break();
    t_fifo();
    t_baud();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R13 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

endmodule